// File: doc/BRIEF.md
# Audio Control Register Slave with Auto-Increment

This block is a two-wire serial bus target that fills a small bank of 8-bit control registers for an audio processing chain. SCL and SDA arrive as plain inputs and are resynchronised onto a fast system clock, which must run at least sixteen times the bit rate. The line is driven through an open-drain enable: when `sda_oe` is high, the pad pulls SDA low.

A write transaction has three parts. The first is the address byte. The second is a subaddress byte, which selects a starting register and whether the index advances after every data byte. The data bytes come last. Every register is visible in parallel on a flat output bus.

A read transaction never returns register contents. Each byte shifted out is a status byte built from two live mute flags. The block samples these flags again after every acknowledge from the master, so the master can poll them repeatedly within one transaction.

Top module: `ctl_reg_slave`

## Requirements
- R1: After reset all nine registers hold 0xFE and `sda_oe` is low.
- R2: The target answers the 7-bit address 1000100 followed by a direction bit in bit 0 (0 = write, 1 = read). It acknowledges by pulling SDA low during the ninth clock of the byte. Bytes travel MSB first.
- R3: An address byte with any other 7-bit address gets no acknowledge. Every byte after it, up to the next START, gets no acknowledge and changes no register.
- R4: In the subaddress byte, bits 3:0 are the register index and bits 7:5 have no effect. An index above 8 gets no acknowledge, and the data that follows is ignored until the next START.
- R5: When subaddress bit 4 is 1, each data byte goes to the next index. The index wraps from 8 back to 0.
- R6: When subaddress bit 4 is 0, every data byte of the transaction rewrites the same register.
- R7: Each data byte in a write is acknowledged and stored unchanged in the selected register.
- R8: In a read, each byte sent holds the soft-mute flag in bit 2 and the zero-crossing mute flag in bit 1. All other bits are 0.
- R9: The status byte is sampled again at the end of every acknowledge from the master. A master non-acknowledge ends the read and releases SDA.
- R10: A repeated START, with no STOP before it, makes the next byte an address byte again.
- R11: A STOP returns the target to idle with SDA released. Bytes clocked after a STOP without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| sda_oe | output | 1 | High to pull SDA low |
| soft_mute_st | input | 1 | Soft-mute active flag for the status byte |
| zc_mute_st | input | 1 | Zero-crossing mute active flag for the status byte |
| regs_flat | output | 72 | Register i on bits [8*i+7 : 8*i] |

## Verification
The embedded assertions guard a set of per-cycle invariants:
- START and STOP never detected in the same cycle.
- After START, the target is in the address phase with SDA released.
- After STOP, the target is idle with SDA released.
- Every register write happens together with an acknowledge and targets an index in range.
- No register changes without a write strobe.
- The bit counter stays in range.

Only the bench's bus scenarios can show the transaction-level results. These are:
- which bytes are acknowledged;
- that data lands MSB first at the right index, with auto-increment wrap and rewrite of a fixed index;
- the status byte contents and their refresh between reads;
- recovery after a repeated START, a mismatch and a STOP.

// File: rtl/ctlslv_pkg.sv
package ctlslv_pkg;
   localparam int BYTE_W = 8;
   localparam int IDX_W  = 4;
   localparam int AINC_BIT = 4;
   localparam int SM_BIT = 2;
   localparam int ZC_BIT = 1;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_SUB,
      PH_WR,
      PH_RD
   } phase_t;
endpackage

// File: rtl/ctlslv_sync.sv
module ctlslv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctlslv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_q, sda_q;

   genvar gi;
   for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[0] <= 1'b1;
               sda_pipe[0] <= 1'b1;
            end else begin
               scl_pipe[0] <= scl_in;
               sda_pipe[0] <= sda_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[gi] <= 1'b1;
               sda_pipe[gi] <= 1'b1;
            end else begin
               scl_pipe[gi] <= scl_pipe[gi-1];
               sda_pipe[gi] <= sda_pipe[gi-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_pipe[STAGES-1];
         sda_q <= sda_pipe[STAGES-1];
      end
   end

   logic scl_now;
   assign scl_now   = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_now & ~scl_q;
   assign scl_fall  = ~scl_now & scl_q;
   assign start_det = scl_now & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;

   assert_edges_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, stop_det}));
endmodule

// File: rtl/ctlslv_regs.sv
module ctlslv_regs
   import ctlslv_pkg::*;
#(
   parameter int NUM_REGS = 9,
   parameter logic [BYTE_W-1:0] RESET_VAL = 8'hFE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IDX_W-1:0]           waddr,
   input  logic [BYTE_W-1:0]          wdata,
   output logic [NUM_REGS*BYTE_W-1:0] q_flat
);
   localparam int FLAT_W = NUM_REGS * BYTE_W;

   genvar gi;
   for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      logic [BYTE_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   r <= RESET_VAL;
         else if (we && (waddr == IDX_W'(gi)))         r <= wdata;
      end
      assign q_flat[gi*BYTE_W +: BYTE_W] = r;
   end

   assert_write_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ({1'b0, waddr} < (IDX_W+1)'(NUM_REGS)));

   assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q_flat));

   logic [FLAT_W-1:0] unused_chk;
   assign unused_chk = q_flat;
endmodule

// File: rtl/ctlslv_link.sv
module ctlslv_link
   import ctlslv_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000100,
   parameter int NUM_REGS = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              soft_mute_st,
   input  logic              zc_mute_st,
   output logic              sda_oe,
   output logic              we,
   output logic [IDX_W-1:0]  waddr,
   output logic [BYTE_W-1:0] wdata
);
   localparam logic [3:0] ACK_SLOT = 4'd8;
   localparam logic [3:0] POST_ACK = 4'd9;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

   phase_t            phase;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              in_ack, rd_mode, m_ack, ainc;
   logic [IDX_W-1:0]  ptr;
   logic [BYTE_W-1:0] status;

   always_comb begin
      status         = '0;
      status[SM_BIT] = soft_mute_st;
      status[ZC_BIT] = zc_mute_st;
   end

   logic idx_ok;
   assign idx_ok = ({1'b0, shreg[IDX_W-1:0]} < (IDX_W+1)'(NUM_REGS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         in_ack  <= 1'b0;
         rd_mode <= 1'b0;
         m_ack   <= 1'b0;
         ainc    <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         we      <= 1'b0;
         waddr   <= '0;
         wdata   <= '0;
      end else begin
         we <= 1'b0;
         if (start_det) begin
            phase  <= PH_ADDR;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
         end else if (phase == PH_RD) begin
            if (scl_rise) begin
               if (bitcnt == ACK_SLOT) m_ack <= !sda_s;
               if (bitcnt < POST_ACK)  bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
               if (bitcnt == POST_ACK) begin
                  if (m_ack) begin
                     shreg  <= status;
                     sda_oe <= !status[BYTE_W-1];
                     bitcnt <= '0;
                  end else begin
                     phase  <= PH_IDLE;
                     sda_oe <= 1'b0;
                  end
               end else if (bitcnt == ACK_SLOT) begin
                  sda_oe <= 1'b0;
               end else begin
                  sda_oe <= !shreg[3'd7 - bitcnt[2:0]];
               end
            end
         end else if (phase != PH_IDLE) begin
            if (scl_rise && !in_ack && (bitcnt < ACK_SLOT)) begin
               shreg  <= {shreg[BYTE_W-2:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
               if (in_ack) begin
                  in_ack <= 1'b0;
                  bitcnt <= '0;
                  if (phase == PH_ADDR && rd_mode) begin
                     phase  <= PH_RD;
                     shreg  <= status;
                     sda_oe <= !status[BYTE_W-1];
                  end else begin
                     sda_oe <= 1'b0;
                     case (phase)
                        PH_ADDR: phase <= PH_SUB;
                        PH_SUB:  phase <= PH_WR;
                        default: begin
                           phase <= PH_WR;
                           if (ainc) ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
                        end
                     endcase
                  end
               end else if (bitcnt == ACK_SLOT) begin
                  case (phase)
                     PH_ADDR: begin
                        if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                           in_ack  <= 1'b1;
                           sda_oe  <= 1'b1;
                           rd_mode <= shreg[0];
                        end else begin
                           phase <= PH_IDLE;
                        end
                     end
                     PH_SUB: begin
                        if (idx_ok) begin
                           in_ack <= 1'b1;
                           sda_oe <= 1'b1;
                           ptr    <= shreg[IDX_W-1:0];
                           ainc   <= shreg[AINC_BIT];
                        end else begin
                           phase <= PH_IDLE;
                        end
                     end
                     default: begin
                        in_ack <= 1'b1;
                        sda_oe <= 1'b1;
                        we     <= 1'b1;
                        waddr  <= ptr;
                        wdata  <= shreg;
                     end
                  endcase
               end
            end
         end
      end
   end

   assert_start_to_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (phase == PH_ADDR) && !sda_oe);

   assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (phase == PH_IDLE) && !sda_oe);

   assert_write_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> sda_oe && in_ack);

   assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= POST_ACK);

   assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe);
endmodule

// File: rtl/ctl_reg_slave.sv
module ctl_reg_slave
   import ctlslv_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000100,
   parameter int NUM_REGS = 9,
   parameter int SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] RESET_VAL = 8'hFE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_in,
   input  logic                       sda_in,
   output logic                       sda_oe,
   input  logic                       soft_mute_st,
   input  logic                       zc_mute_st,
   output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
   if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs
      $error("ctl_reg_slave: NUM_REGS must lie in 1..16");
   end

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic we;
   logic [IDX_W-1:0]  waddr;
   logic [BYTE_W-1:0] wdata;

   ctlslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   ctlslv_link #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_link (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .soft_mute_st(soft_mute_st), .zc_mute_st(zc_mute_st),
      .sda_oe(sda_oe), .we(we), .waddr(waddr), .wdata(wdata)
   );

   ctlslv_regs #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .q_flat(regs_flat)
   );
endmodule

// File: tb/ctl_reg_slave_bench.sv
module ctl_reg_slave_bench;
   localparam int Q = 8;
   typedef logic [7:0] bq_t[$];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic soft_st = 1'b0;
   logic zc_st = 1'b0;
   logic dut_oe;
   logic sda_bus;
   logic [71:0] regs_flat;

   int tot = 0;
   int bad = 0;
   logic cmp_en = 1'b0;
   logic [7:0] exp_r [9];

   always #5 clk = ~clk;
   assign sda_bus = m_sda & ~dut_oe;

   ctl_reg_slave u_ctl_reg_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
      .sda_oe(dut_oe), .soft_mute_st(soft_st), .zc_mute_st(zc_st),
      .regs_flat(regs_flat)
   );

   task automatic chk(input string req, input int act, input int expv);
      tot++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // reference comparison on every clock while the bus is quiet (R7)
   always @(negedge clk) begin
      if (cmp_en) begin
         for (int i = 0; i < 9; i++)
            chk("R7 register mirror", int'(regs_flat[i*8 +: 8]), int'(exp_r[i]));
      end
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
      end
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
      ack = (sda_bus == 1'b0);
      wq(Q); m_scl = 1'b0; wq(Q);
   endtask

   task automatic rd_byte(input logic do_ack, input logic nsoft, input logic nzc,
                          output logic [7:0] d);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q); m_scl = 1'b1; wq(Q); d[i] = sda_bus; wq(Q); m_scl = 1'b0;
      end
      soft_st = nsoft; zc_st = nzc;
      wq(Q); m_sda = !do_ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
      m_sda = 1'b1;
   endtask

   task automatic wr_txn(input logic [7:0] ab, input logic [7:0] sb, input bq_t dat,
                         input string req);
      logic a, ok_a, ok_s;
      int p;
      cmp_en = 1'b0;
      bus_start();
      wr_byte(ab, a);
      ok_a = (ab[7:1] == 7'b1000100) && !ab[0];
      chk({req, " address ack"}, int'(a), int'(ok_a));
      wr_byte(sb, a);
      ok_s = ok_a && (sb[3:0] <= 4'd8);
      chk({req, " subaddress ack"}, int'(a), int'(ok_s));
      p = int'(sb[3:0]);
      foreach (dat[k]) begin
         wr_byte(dat[k], a);
         chk({req, " data ack"}, int'(a), int'(ok_s));
         if (ok_s) begin
            exp_r[p] = dat[k];
            if (sb[4]) p = (p == 8) ? 0 : p + 1;
         end
      end
      bus_stop();
      cmp_en = 1'b1;
      wq(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tot++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] d;
      for (int i = 0; i < 9; i++) exp_r[i] = 8'hFE;
      wq(5);
      rst_n = 1'b1;
      wq(3);
      // R1: reset state
      for (int i = 0; i < 9; i++) chk("R1 reset value", int'(regs_flat[i*8 +: 8]), 8'hFE);
      chk("R1 sda released", int'(dut_oe), 0);
      cmp_en = 1'b1;

      // R2 R5 R7: auto-increment from index 0
      wr_txn(8'h88, 8'h10, '{8'h5A, 8'h81, 8'h3C}, "R2 R5");
      // R4 bits 7:5 ignored, R6 fixed index rewrite
      wr_txn(8'h88, 8'hE5, '{8'h66, 8'h77}, "R4 R6");
      // R5 wrap from 8 to 0
      wr_txn(8'h88, 8'h17, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5 wrap");
      // R3 address mismatch
      wr_txn(8'h8A, 8'h10, '{8'h99, 8'h98}, "R3 mismatch");
      wr_txn(8'h08, 8'h02, '{8'h97}, "R3 mismatch");
      // R4 index above 8
      wr_txn(8'h88, 8'h19, '{8'h55, 8'h56}, "R4 bad index");

      // R10 repeated start
      cmp_en = 1'b0;
      bus_start();
      wr_byte(8'h88, a); chk("R10 first address ack", int'(a), 1);
      wr_byte(8'h03, a); chk("R10 first subaddress ack", int'(a), 1);
      wr_byte(8'hA5, a); chk("R10 first data ack", int'(a), 1);
      exp_r[3] = 8'hA5;
      m_sda = 1'b1; wq(Q);
      bus_start();
      wr_byte(8'h88, a); chk("R10 address after repeated start", int'(a), 1);
      wr_byte(8'h04, a); chk("R10 subaddress after repeated start", int'(a), 1);
      wr_byte(8'hC3, a); chk("R10 data after repeated start", int'(a), 1);
      exp_r[4] = 8'hC3;
      bus_stop();
      cmp_en = 1'b1;
      wq(4);

      // R8 R9 reads
      soft_st = 1'b1; zc_st = 1'b0;
      cmp_en = 1'b0;
      bus_start();
      wr_byte(8'h89, a); chk("R2 read address ack", int'(a), 1);
      rd_byte(1'b1, 1'b0, 1'b1, d); chk("R8 status soft only", int'(d), 8'h04);
      rd_byte(1'b1, 1'b1, 1'b1, d); chk("R9 status refreshed", int'(d), 8'h02);
      rd_byte(1'b0, 1'b0, 1'b0, d); chk("R8 status both flags", int'(d), 8'h06);
      wq(2);
      chk("R9 released after master nack", int'(dut_oe), 0);
      bus_stop();
      cmp_en = 1'b1;
      wq(4);
      chk("R11 released after stop", int'(dut_oe), 0);

      // R11 bytes without start are ignored
      cmp_en = 1'b0;
      m_scl = 1'b0; wq(Q);
      wr_byte(8'h88, a); chk("R11 no ack without start", int'(a), 0);
      wr_byte(8'h00, a); chk("R11 no ack without start", int'(a), 0);
      wr_byte(8'h12, a); chk("R11 no ack without start", int'(a), 0);
      m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
      cmp_en = 1'b1;
      wq(10);

      // final register state after all scenarios (R5 R6 R7)
      chk("R5 reg0 after wrap", int'(regs_flat[0 +: 8]), 8'h33);
      chk("R5 reg1 after wrap", int'(regs_flat[8 +: 8]), 8'h44);
      chk("R7 reg2", int'(regs_flat[16 +: 8]), 8'h3C);
      chk("R6 reg5", int'(regs_flat[40 +: 8]), 8'h77);
      chk("R5 reg8", int'(regs_flat[64 +: 8]), 8'h22);

      cmp_en = 1'b0;
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
   end
endmodule